// File: doc/BRIEF.md
# Configuration Word Store and Commit Controller

The block keeps a small set of configuration words in volatile registers that a host fills from a decoded serial bit stream, and lets the host copy the whole set into a nonvolatile register bank on command. Bits arrive one per strobe, most significant bit first. Each group of `WORD_W` bits forms one word. Words fill in ascending index order, and the controller goes back to idle once the last word is complete.

From idle the host can issue one of two commit commands. Either one copies every volatile word into the nonvolatile bank and then holds the controller busy for a fixed, parameterised wait. The second command also sets a lock bit that is kept in the nonvolatile bank. Once the lock is set, the contents can no longer be changed. The nonvolatile bank and the lock bit are not cleared by reset. After every reset, the volatile registers are reloaded from the bank.

Top module: `cfg_commit_ctrl`

## Requirements
- R1: While `rst_ni` is low, `cfg_words_o` is zero and `busy_o` is low. In the first cycle after reset is released, `cfg_words_o` equals `nv_words_o`.
- R2: Accepted bits are shifted in MSB first. Every `WORD_W` accepted bits form one word, written to word 0, then 1, and so on up to `NUM_WORDS-1`. Word i sits at `cfg_words_o[i*WORD_W +: WORD_W]` and is visible from the cycle after its last bit.
- R3: After `NUM_WORDS*WORD_W` accepted bits the controller is idle again, and the next accepted bit starts at word 0.
- R4: Serial writes never change `nv_words_o`. The bank changes only in the cycle after `nv_we_o` is high.
- R5: Command `cmd_i`=01 (commit) in idle drives `nv_we_o` to all ones for exactly one cycle, in the cycle after the command. From the following cycle, `nv_words_o` equals the volatile words.
- R6: `busy_o` is high for exactly `WAIT_CYCLES` cycles, starting in the cycle after a commit command. Bits and commands that arrive while busy are ignored.
- R7: Command `cmd_i`=10 (commit with lock) behaves like R5 and R6, and additionally `locked_o` goes high together with the bank update. The lock stays high across reset.
- R8: While `locked_o` is high, bits and commit commands are ignored: `cfg_words_o`, `nv_words_o` and `busy_o` do not change.
- R9: A command is acted on only in idle, and it takes precedence over a bit strobed in the same cycle, which is dropped. While a load is in progress, commit commands are ignored. Command 11 (restart) abandons a partial load and resets the pointer to bit 0 of word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Decoded serial data bit |
| bit_valid_i | input | 1 | Strobe qualifying `bit_i` |
| cmd_i | input | 2 | 00 none, 01 commit, 10 commit with lock, 11 restart load |
| cfg_words_o | output | NUM_WORDS*WORD_W | Volatile configuration words, word i at `[i*WORD_W +: WORD_W]` |
| nv_words_o | output | NUM_WORDS*WORD_W | Nonvolatile bank contents, same layout |
| nv_we_o | output | NUM_WORDS | Per-word bank write strobes |
| busy_o | output | 1 | High during the commit wait |
| locked_o | output | 1 | Permanent lock status |

## Verification
A word becomes visible one cycle after the clock edge that takes in its last bit. The write strobe appears one cycle after a commit command, and the bank contents follow one cycle after the strobe. `busy_o` rises one cycle after the command, stays high for `WAIT_CYCLES` samples and is low at the next sample. The bench drives every input on the falling edge and samples on the following falling edge, so each check falls exactly one register stage after the edge that caused it. The busy window is measured by counting high samples. Ignored-input cases are checked by reading the words and the bank after the stimulus ends: they must be unchanged, and a full reload after the stimulus must land on word 0.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;
  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_LOAD,
    ST_COMMIT,
    ST_COMMIT_LOCK
  } state_e;

  typedef enum logic [1:0] {
    CMD_NONE        = 2'b00,
    CMD_COMMIT      = 2'b01,
    CMD_COMMIT_LOCK = 2'b10,
    CMD_RESTART     = 2'b11
  } cmd_e;
endpackage

// File: rtl/cfg_shift_loader.sv
module cfg_shift_loader #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 6,
  localparam int BIT_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1,
  localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              bit_i,
  input  logic              clear_i,
  output logic              word_done_o,
  output logic              last_word_o,
  output logic [IDX_W-1:0]  word_idx_o,
  output logic [WORD_W-1:0] word_data_o
);
  logic [WORD_W-1:0] shreg_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              word_end;

  assign word_end    = (bit_cnt_q == BIT_W'(WORD_W - 1));
  assign word_done_o = accept_i && word_end;
  assign last_word_o = (idx_q == IDX_W'(NUM_WORDS - 1));
  assign word_idx_o  = idx_q;
  assign word_data_o = {shreg_q[WORD_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
      idx_q     <= '0;
    end else if (clear_i) begin
      bit_cnt_q <= '0;
      idx_q     <= '0;
    end else if (accept_i) begin
      shreg_q <= word_data_o;
      if (word_end) begin
        bit_cnt_q <= '0;
        idx_q     <= last_word_o ? '0 : idx_q + 1'b1;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  assert_idx_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(NUM_WORDS));
  assert_word_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_o && !last_word_o && !clear_i) |=> (idx_q == $past(idx_q) + 1'b1));
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_o && last_word_o) |=> (idx_q == '0 && bit_cnt_q == '0));
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int WAIT_CYCLES = 2500000,
  localparam int CNT_W      = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= CNT_W'(WAIT_CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_wait_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(WAIT_CYCLES - 1));
  assert_wait_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/cfg_nv_bank.sv
module cfg_nv_bank #(
  parameter int                          WORD_W    = 8,
  parameter int                          NUM_WORDS = 6,
  parameter logic [NUM_WORDS*WORD_W-1:0] NV_INIT   = '0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_WORDS-1:0]        we_i,
  input  logic [NUM_WORDS*WORD_W-1:0] wdata_i,
  input  logic                        lock_set_i,
  output logic [NUM_WORDS*WORD_W-1:0] words_o,
  output logic                        locked_o
);
  // Storage deliberately has no reset: contents survive rst_ni.
  logic [NUM_WORDS*WORD_W-1:0] words_q = NV_INIT;
  logic                        lock_q  = 1'b0;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (we_i[i]) words_q[i*WORD_W +: WORD_W] <= wdata_i[i*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk_i) begin
    if (lock_set_i) lock_q <= 1'b1;
  end

  assign words_o  = words_q;
  assign locked_o = lock_q;

  assert_nv_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) == '0) |-> $stable(words_o));
  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
  import cfg_commit_pkg::*;
#(
  parameter int                          WORD_W      = 8,
  parameter int                          NUM_WORDS   = 6,
  parameter int                          WAIT_CYCLES = 2500000,
  parameter logic [NUM_WORDS*WORD_W-1:0] NV_INIT     = '0,
  localparam int                         IDX_W       = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int                         TOT_W       = NUM_WORDS * WORD_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_i,
  input  logic                 bit_valid_i,
  input  logic [1:0]           cmd_i,
  output logic [TOT_W-1:0]     cfg_words_o,
  output logic [TOT_W-1:0]     nv_words_o,
  output logic [NUM_WORDS-1:0] nv_we_o,
  output logic                 busy_o,
  output logic                 locked_o
);
  state_e             state_q, state_d;
  cmd_e               cmd;
  logic               accept, clear, start, first_q;
  logic               word_done, last_word, timer_done, locked;
  logic [IDX_W-1:0]   word_idx;
  logic [WORD_W-1:0]  word_data;
  logic [TOT_W-1:0]   vol_q;
  logic [TOT_W-1:0]   nv_words;

  assign cmd = cmd_e'(cmd_i);

  // Command beats bit in idle; restart beats bit while loading.
  always_comb begin
    accept = 1'b0;
    if (bit_valid_i && !locked) begin
      if (state_q == ST_IDLE) accept = (cmd == CMD_NONE);
      if (state_q == ST_LOAD) accept = (cmd != CMD_RESTART);
    end
  end

  assign clear = (state_q == ST_LOAD) && (cmd == CMD_RESTART);

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    unique case (state_q)
      ST_BOOT: state_d = ST_IDLE;
      ST_IDLE: begin
        if (!locked) begin
          if (cmd == CMD_COMMIT) begin
            state_d = ST_COMMIT;
            start   = 1'b1;
          end else if (cmd == CMD_COMMIT_LOCK) begin
            state_d = ST_COMMIT_LOCK;
            start   = 1'b1;
          end else if (accept) begin
            state_d = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        if (clear)                         state_d = ST_IDLE;
        else if (word_done && last_word)   state_d = ST_IDLE;
      end
      ST_COMMIT, ST_COMMIT_LOCK: begin
        if (!first_q && timer_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      first_q <= start;
    end
  end

  cfg_shift_loader #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_loader (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .bit_i       (bit_i),
    .clear_i     (clear),
    .word_done_o (word_done),
    .last_word_o (last_word),
    .word_idx_o  (word_idx),
    .word_data_o (word_data)
  );

  cfg_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .done_o  (timer_done)
  );

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_vol
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        vol_q[i*WORD_W +: WORD_W] <= '0;
      else if (state_q == ST_BOOT)
        vol_q[i*WORD_W +: WORD_W] <= nv_words[i*WORD_W +: WORD_W];
      else if (word_done && word_idx == IDX_W'(i))
        vol_q[i*WORD_W +: WORD_W] <= word_data;
    end
  end

  assign nv_we_o = {NUM_WORDS{first_q}};

  cfg_nv_bank #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .NV_INIT(NV_INIT)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (nv_we_o),
    .wdata_i    (vol_q),
    .lock_set_i (first_q && state_q == ST_COMMIT_LOCK),
    .words_o    (nv_words),
    .locked_o   (locked)
  );

  assign cfg_words_o = vol_q;
  assign nv_words_o  = nv_words;
  assign busy_o      = (state_q == ST_COMMIT) || (state_q == ST_COMMIT_LOCK);
  assign locked_o    = locked;

  assert_we_in_commit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_we_o != '0) |-> busy_o);
  assert_we_all_or_none_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_we_o == '0) || (&nv_we_o));
  assert_we_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_we_o != '0) |=> (nv_we_o == '0));
  assert_busy_no_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !word_done);
  assert_locked_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && state_q == ST_IDLE) |=> !busy_o);
  assert_load_no_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |=> !busy_o);
endmodule

// File: tb/tb_cfg_commit_ctrl.sv
module tb_cfg_commit_ctrl;
  localparam int          W   = 8;
  localparam int          N   = 6;
  localparam int          WT  = 20;
  localparam logic [47:0] NVI = 48'h5A3C_F00F_1234;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bit_i = 1'b0;
  logic          bit_valid_i = 1'b0;
  logic [1:0]    cmd_i = 2'b00;
  logic [N*W-1:0] cfg_words_o, nv_words_o;
  logic [N-1:0]  nv_we_o;
  logic          busy_o, locked_o;

  always #2 clk_i = ~clk_i;

  cfg_commit_ctrl #(.WORD_W(W), .NUM_WORDS(N), .WAIT_CYCLES(WT), .NV_INIT(NVI)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .cmd_i(cmd_i), .cfg_words_o(cfg_words_o), .nv_words_o(nv_words_o),
    .nv_we_o(nv_we_o), .busy_o(busy_o), .locked_o(locked_o)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [W-1:0] ld_w [N];
  logic [W-1:0] exp_vol [N];
  logic [W-1:0] exp_nv [N];
  logic         exp_lock = 1'b0;

  function automatic logic [N*W-1:0] pack(input logic [W-1:0] a [N]);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = a[i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input int gap);
    bit_valid_i = 1'b1;
    bit_i       = b;
    @(negedge clk_i);
    bit_valid_i = 1'b0;
    repeat (gap) @(negedge clk_i);
  endtask

  task automatic load_all(input int max_gap, input bit take);
    for (int w = 0; w < N; w++)
      for (int b = W - 1; b >= 0; b--)
        send_bit(ld_w[w][b], (max_gap > 0) ? int'($urandom_range(0, max_gap)) : 0);
    if (take) for (int w = 0; w < N; w++) exp_vol[w] = ld_w[w];
  endtask

  task automatic do_commit(input logic [1:0] c, input bit inject);
    int cnt;
    cmd_i = c;
    @(negedge clk_i);
    cmd_i = 2'b00;
    chk(busy_o == 1'b1 && nv_we_o == '1, "R5 strobe after commit", {busy_o, nv_we_o}, {1'b1, {N{1'b1}}});
    cnt = 1;
    while (cnt < 1000) begin
      bit_valid_i = inject ? 1'($urandom) : 1'b0;
      bit_i       = 1'($urandom);
      if (inject && cnt == 2) cmd_i = 2'($urandom);
      @(negedge clk_i);
      cmd_i = 2'b00;
      if (cnt == 1) begin
        chk(nv_we_o == '0, "R5 strobe single cycle", nv_we_o, 0);
        chk(nv_words_o == pack(exp_vol), "R5 bank takes volatile words", nv_words_o, pack(exp_vol));
        if (c == 2'b10) chk(locked_o == 1'b1, "R7 lock with bank update", locked_o, 1);
      end
      if (!busy_o) break;
      cnt++;
    end
    bit_valid_i = 1'b0;
    chk(cnt == WT, "R6 busy length", cnt, WT);
    for (int i = 0; i < N; i++) exp_nv[i] = exp_vol[i];
    if (c == 2'b10) exp_lock = 1'b1;
    chk(cfg_words_o == pack(exp_vol), "R6 inputs ignored while busy", cfg_words_o, pack(exp_vol));
    chk(nv_words_o == pack(exp_nv), "R5 bank after wait", nv_words_o, pack(exp_nv));
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < N; i++) begin
      exp_nv[i]  = NVI[i*W +: W];
      exp_vol[i] = NVI[i*W +: W];
    end
    #1;
    chk(cfg_words_o == '0 && busy_o == 1'b0, "R1 reset state", {busy_o, cfg_words_o}, 0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cfg_words_o == NVI, "R1 reload from bank", cfg_words_o, NVI);
    chk(locked_o == 1'b0, "R8 unlocked at start", locked_o, 0);

    // R2 per-word placement after the first word
    ld_w[0] = 8'hA5;
    for (int b = W - 1; b >= 0; b--) send_bit(ld_w[0][b], 0);
    exp_vol[0] = 8'hA5;
    chk(cfg_words_o == pack(exp_vol), "R2 first word MSB first", cfg_words_o, pack(exp_vol));
    // R9 commit during load is ignored
    cmd_i = 2'b01;
    @(negedge clk_i);
    cmd_i = 2'b00;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R9 commit ignored while loading", busy_o, 0);
    for (int w = 1; w < N; w++) begin
      ld_w[w] = 8'(w * 17 + 3);
      for (int b = W - 1; b >= 0; b--) send_bit(ld_w[w][b], 0);
      exp_vol[w] = ld_w[w];
    end
    chk(cfg_words_o == pack(exp_vol), "R3 full load after ignored cmd", cfg_words_o, pack(exp_vol));
    chk(nv_words_o == pack(exp_nv), "R4 bank untouched by load", nv_words_o, pack(exp_nv));

    // R9 restart drops a partial word
    for (int k = 0; k < 5; k++) send_bit(1'b1, 0);
    cmd_i = 2'b11;
    @(negedge clk_i);
    cmd_i = 2'b00;
    for (int i = 0; i < N; i++) ld_w[i] = 8'($urandom);
    load_all(0, 1'b1);
    chk(cfg_words_o == pack(exp_vol), "R9 restart realigns pointer", cfg_words_o, pack(exp_vol));

    // R9 command beats simultaneous bit in idle
    bit_valid_i = 1'b1;
    bit_i = 1'b1;
    do_commit(2'b01, 1'b0);
    for (int i = 0; i < N; i++) ld_w[i] = 8'($urandom);
    load_all(0, 1'b1);
    chk(cfg_words_o == pack(exp_vol), "R9 bit dropped under command", cfg_words_o, pack(exp_vol));

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < N; i++) ld_w[i] = 8'($urandom);
      load_all(2, 1'b1);
      chk(cfg_words_o == pack(exp_vol), "R2 R3 random load", cfg_words_o, pack(exp_vol));
      chk(nv_words_o == pack(exp_nv), "R4 bank unchanged by load", nv_words_o, pack(exp_nv));
      if ($urandom_range(0, 2) != 0) do_commit(2'b01, 1'b1);
      repeat ($urandom_range(0, 3)) @(negedge clk_i);
    end

    // Lock
    for (int i = 0; i < N; i++) ld_w[i] = 8'($urandom);
    load_all(0, 1'b1);
    do_commit(2'b10, 1'b0);
    chk(locked_o == 1'b1, "R7 locked after wait", locked_o, 1);
    for (int i = 0; i < N; i++) ld_w[i] = ~exp_vol[i];
    load_all(0, 1'b0);
    chk(cfg_words_o == pack(exp_vol), "R8 writes ignored when locked", cfg_words_o, pack(exp_vol));
    cmd_i = 2'b01;
    @(negedge clk_i);
    cmd_i = 2'b00;
    chk(busy_o == 1'b0 && nv_we_o == '0, "R8 commit ignored when locked", {busy_o, nv_we_o}, 0);
    @(negedge clk_i);
    chk(nv_words_o == pack(exp_nv), "R8 bank frozen", nv_words_o, pack(exp_nv));

    // Reset keeps bank and lock
    rst_ni = 1'b0;
    #1;
    chk(cfg_words_o == '0 && busy_o == 1'b0, "R1 reset clears volatile", cfg_words_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(locked_o == 1'b1, "R7 lock survives reset", locked_o, 1);
    chk(cfg_words_o == pack(exp_nv), "R1 reload after reset", cfg_words_o, pack(exp_nv));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule